// File: doc/BRIEF.md
# Pipelined Fixed-Priority Bus Arbiter with Shared Lock

This block decides which of several bus masters drives a shared bus next. Each master has its own request input and its own grant output. While the current transfer is still running, the arbiter registers a one-hot grant for the master that should own the bus next. That master takes ownership on the first rising edge where the bus wait response is low. As a result, handover never costs a separate arbitration cycle.

Priority is fixed by index. Index 0 is the highest and is meant for the test-access master. The highest index is the default master, which is granted whenever no master is requesting. A shared lock line, driven by the current owner, keeps that owner in place across transfers that must not be split. A higher-priority requester therefore waits until the lock drops. The lock has no effect when the default master owns the bus and has no transfer in progress.

Top module: `bus_arbiter_lk`

## Requirements
- R1: During and right after reset, the grant vector is one-hot on the default master (index NUM_MASTERS-1), and the owner index equals NUM_MASTERS-1.
- R2: In every cycle, exactly one bit of the grant vector is high.
- R3: With the lock not effective, the grant registered at an edge goes to the lowest-index master whose request bit is 1 at that edge.
- R4: With the lock not effective and all request bits 0 at an edge, the registered grant goes to the default master.
- R5: At an edge where the wait input is 0 and the lock is not effective, the owner index takes the index of the grant that was high before that edge. At an edge where the wait input is 1, the owner index keeps its value.
- R6: At an edge where the lock is effective, the owner index keeps its value, and the registered grant goes to that owner regardless of requests.
- R7: The lock is effective only when the lock input is 1 and it is not the case that the owner is the default master with the transfer-active input 0. In that idle-default case, the lock input changes neither the grant nor the ownership.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_MASTERS | Request bit per master; bit 0 has the highest priority |
| lock_i | input | 1 | Shared lock line driven by the current owner |
| wait_i | input | 1 | Bus wait response; 1 extends the current transfer |
| xfer_i | input | 1 | 1 when the current owner has a transfer in progress |
| grant_o | output | NUM_MASTERS | Registered one-hot grant |
| owner_o | output | $clog2(NUM_MASTERS) | Index of the master that owns the bus |

## Verification
The assertions assume the lock input is meaningful only as a level sampled at each rising edge. They place no constraint on how requests relate to lock or wait. This holds because the arbiter itself decides which owner the lock belongs to. The stimulus drives every combination of four request bits, lock, wait and transfer-active on a changing sequence, with inputs changing only at falling edges. Consecutive patterns therefore reach handovers, locked stretches and idle-default states from many preceding owners.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Where the next grant comes from
    typedef enum logic [1:0] {
        SRC_PRIO    = 2'd0,
        SRC_DEFAULT = 2'd1,
        SRC_HOLD    = 2'd2
    } grant_src_e;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] pick,
    output logic             any
);

    // seen[k] is high when any request below index k is set
    logic [WIDTH:0] seen;

    assign seen[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < WIDTH; k++) begin : g_chain
            assign seen[k+1] = seen[k] | req[k];
            assign pick[k]   = req[k] & ~seen[k];
        end
    endgenerate

    assign any = seen[WIDTH];

endmodule

// File: rtl/arb_onehot_enc.sv
module arb_onehot_enc #(
    parameter int WIDTH = 4,
    parameter int IDX_W = 2
) (
    input  logic [WIDTH-1:0] onehot,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (onehot[k]) begin
                idx = idx | IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/bus_arbiter_lk.sv
module bus_arbiter_lk #(
    parameter int NUM_MASTERS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_MASTERS-1:0]         req_i,
    input  logic                           lock_i,
    input  logic                           wait_i,
    input  logic                           xfer_i,
    output logic [NUM_MASTERS-1:0]         grant_o,
    output logic [$clog2(NUM_MASTERS)-1:0] owner_o
);

    import arb_pkg::*;

    localparam int IDX_W = $clog2(NUM_MASTERS);
    localparam logic [IDX_W-1:0] DEF_SEL = IDX_W'(NUM_MASTERS - 1);
    localparam logic [NUM_MASTERS-1:0] DEF_ONEHOT = NUM_MASTERS'(1) << (NUM_MASTERS - 1);

    typedef struct packed {
        logic [NUM_MASTERS-1:0] grant;
        logic [IDX_W-1:0]       owner;
    } arb_state_t;

    arb_state_t state_q, state_d;

    logic [NUM_MASTERS-1:0] pick;
    logic                   pick_any;
    logic [IDX_W-1:0]       grant_idx;
    logic                   lock_eff;
    grant_src_e             src;

    arb_prio_pick #(
        .WIDTH(NUM_MASTERS)
    ) u_pick (
        .req (req_i),
        .pick(pick),
        .any (pick_any)
    );

    arb_onehot_enc #(
        .WIDTH(NUM_MASTERS),
        .IDX_W(IDX_W)
    ) u_enc (
        .onehot(state_q.grant),
        .idx   (grant_idx)
    );

    always_comb begin
        state_d  = state_q;
        // lock counts unless the default master sits idle on the bus
        lock_eff = lock_i && !((state_q.owner == DEF_SEL) && !xfer_i);

        if (lock_eff) begin
            src = SRC_HOLD;
        end else if (pick_any) begin
            src = SRC_PRIO;
        end else begin
            src = SRC_DEFAULT;
        end

        case (src)
            SRC_HOLD: state_d.grant = NUM_MASTERS'(1) << state_q.owner;
            SRC_PRIO: state_d.grant = pick;
            default:  state_d.grant = DEF_ONEHOT;
        endcase

        // handover only at the end of a transfer and never under lock
        if (!wait_i && !lock_eff) begin
            state_d.owner = grant_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.grant <= DEF_ONEHOT;
            state_q.owner <= DEF_SEL;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant_o = state_q.grant;
    assign owner_o = state_q.owner;

    // R1
    reset_default_chk: assert property (@(posedge clk)
        !rst_n |=> (grant_o == DEF_ONEHOT && owner_o == DEF_SEL));

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1);

    // R3
    top_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_i && req_i[0]) |=> grant_o[0]);

    // R4
    idle_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_i && req_i == '0) |=> grant_o[NUM_MASTERS-1]);

    // R5
    owner_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_i |=> $stable(owner_o));

    // R5
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_i && !lock_i) |=> (owner_o == $past(grant_idx)));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && xfer_i) |=> ($stable(owner_o) && grant_o == (NUM_MASTERS'(1) << owner_o)));

    // R7
    lock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !xfer_i && owner_o == DEF_SEL && req_i[0]) |=> grant_o[0]);

endmodule

// File: tb/sim_bus_arbiter_lk.sv
module sim_bus_arbiter_lk;

    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int W = 2;
    localparam int DEF = N - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         lock = 1'b0;
    logic         wt = 1'b0;
    logic         xfer = 1'b0;
    logic [N-1:0] grant;
    logic [W-1:0] owner;

    int checks = 0;
    int errors = 0;
    int exp_g = DEF;
    int exp_o = DEF;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_arbiter_lk #(.NUM_MASTERS(N)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req),
        .lock_i (lock),
        .wait_i (wt),
        .xfer_i (xfer),
        .grant_o(grant),
        .owner_o(owner)
    );

    function automatic int lowest(input logic [N-1:0] r);
        for (int k = 0; k < N; k++) begin
            if (r[k]) return k;
        end
        return DEF;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 grant", int'(grant), 1 << DEF);
        check("R1 owner", int'(owner), DEF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 grant after release", int'(grant), 1 << DEF);

        for (int i = 0; i < 1024; i++) begin
            int  v;
            bit  leff;
            int  nxt_g;
            int  nxt_o;
            string gtag;
            string otag;
            v    = (i * 53 + 7) % 128;
            req  = v[3:0];
            lock = v[4];
            wt   = v[5];
            xfer = v[6];
            @(posedge clk);
            leff  = lock && !(exp_o == DEF && !xfer);
            nxt_o = (!wt && !leff) ? exp_g : exp_o;
            if (leff) begin
                nxt_g = exp_o;
                gtag  = "R6 grant held";
            end else if (req == '0) begin
                nxt_g = DEF;
                gtag  = lock ? "R7 idle lock, R4 default" : "R4 default grant";
            end else begin
                nxt_g = lowest(req);
                gtag  = lock ? "R7 idle lock, R3 priority" : "R3 priority grant";
            end
            if (leff)      otag = "R6 owner held";
            else if (wt)   otag = "R5 owner waits";
            else if (lock) otag = "R7 lock ignored handover";
            else           otag = "R5 handover";
            exp_g = nxt_g;
            exp_o = nxt_o;
            @(negedge clk);
            check(gtag, int'(grant), 1 << exp_g);
            check(otag, int'(owner), exp_o);
            check("R2 one-hot", $countones(grant), 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule